// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block sends single bytes onto an I2C bus as the master. A host places a byte, which is either a 7-bit slave address followed by the read/write bit or a plain data byte, into a transmit holding register with a one-cycle write strobe. The block then generates nine SCL pulses from its own baud divider. It presents the byte on SDA most significant bit first and lets go of SDA for the acknowledge pulse. At the end of that pulse it records what the slave put on the line.

Both bus lines are open-drain. Each has an output-enable that pulls the line low when set and releases it otherwise. When a byte is finished, the generator stops with SCL pulled low and SDA released. The bus stays parked this way until the host writes the next byte. The host sees four flags: holding register full, write collision, acknowledge status and byte done. Start and stop conditions, reception and arbitration are handled elsewhere.

Top module: `i2c_byte_tx`

## Requirements
- R1: A synchronous active-high reset releases SCL and SDA (both output-enables 0) and clears all four flags.
- R2: A write accepted while idle pulls SCL low on the next cycle. SCL then toggles every `half_period_i` clocks, with 0 treated as 1, for nine low/high pulses. `half_period_i` must stay constant during a byte.
- R3: Data bits go out MSB first. The first bit appears with the accepting write, and each later bit appears on the SCL falling edge that follows the previous bit's high phase. SDA never changes while SCL is released.
- R4: From the eighth SCL falling edge until the byte ends, SDA is released so the slave can answer.
- R5: On the ninth SCL falling edge, the acknowledge flag takes the SDA line level seen during the last system clock of the ninth high phase: 0 for a low line (ACK), 1 for a high line (NACK). At all other times it holds its value.
- R6: The full flag rises with an accepted write and falls on the eighth SCL falling edge.
- R7: A write arriving while a byte is in flight is rejected and sets the collision flag. "In flight" runs from the accepting edge through the ninth falling edge, inclusive. The rejected write leaves the byte in flight, and the bits it puts on SDA, unchanged.
- R8: The collision flag is cleared only by the `wcol_clr_i` strobe. A new collision in the same cycle as the strobe keeps it set.
- R9: The done flag is set on the ninth SCL falling edge and cleared only by the `done_clr_i` strobe. Setting wins over a clear in the same cycle.
- R10: After the ninth falling edge, SCL stays low and SDA released with no clock activity until the next write. That write starts the next byte with SCL already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period_i | input | DIV_W | SCL half-period in system clocks |
| buf_wr_i | input | 1 | Host write strobe for the holding register |
| buf_data_i | input | DATA_W | Byte to send |
| done_clr_i | input | 1 | Clear strobe for the done flag |
| wcol_clr_i | input | 1 | Clear strobe for the collision flag |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| buf_full_o | output | 1 | Holding register full |
| wcol_o | output | 1 | Write collision flag |
| ack_stat_o | output | 1 | Acknowledge status, 1 = NACK |
| done_o | output | 1 | Byte done interrupt flag |

## Verification
Some properties are checked on every cycle. SDA must stay still while SCL is released. The divider must count down steadily between ticks, and the holding register must stay frozen during a byte. A write in flight must raise the collision flag, and the bus must park correctly when the byte ends. The cycle-by-cycle reference model covers what no local property can show: the exact tick positions for several half-periods (including 0), the MSB-first bit order for different bytes, ACK versus NACK capture, a collision on the very edge that finishes a byte, clear strobes that coincide with a new set, and back-to-back bytes starting from the parked bus.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/i2ctx_baud.sv
module i2ctx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t q, d;

    assign tick_o = run_i && (q.cnt <= DIV_W'(1));

    always_comb begin
        d = q;
        if (!run_i || tick_o) d.cnt = half_i;
        else                  d.cnt = q.cnt - DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R2
    baud_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !tick_o) |=> (q.cnt == $past(q.cnt) - DIV_W'(1)));
endmodule

// File: rtl/i2ctx_seq.sv
module i2ctx_seq
    import i2ctx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              eighth_fall_o,
    output logic              finish_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              busy;
        scl_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
        logic              scl_oe;
        logic              sda_oe;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d             = q;
        eighth_fall_o = 1'b0;
        finish_o      = 1'b0;
        if (accept_i) begin
            d.busy   = 1'b1;
            d.ph     = PH_LOW;
            d.cnt    = '0;
            d.hold   = data_i;
            d.scl_oe = 1'b1;
            d.sda_oe = ~data_i[DATA_W-1];
        end else if (q.busy && tick_i) begin
            if (q.ph == PH_LOW) begin
                d.ph     = PH_HIGH;
                d.scl_oe = 1'b0;
            end else begin
                d.ph     = PH_LOW;
                d.scl_oe = 1'b1;
                if (q.cnt == CNT_W'(DATA_W)) begin
                    d.busy   = 1'b0;
                    d.sda_oe = 1'b0;
                    finish_o = 1'b1;
                end else if (q.cnt == CNT_W'(DATA_W - 1)) begin
                    d.cnt         = CNT_W'(DATA_W);
                    d.sda_oe      = 1'b0;
                    eighth_fall_o = 1'b1;
                end else begin
                    d.cnt    = q.cnt + CNT_W'(1);
                    d.sda_oe = ~q.hold[IDX_W'(DATA_W - 2) - q.cnt[IDX_W-1:0]];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign busy_o   = q.busy;
    assign scl_oe_o = q.scl_oe;
    assign sda_oe_o = q.sda_oe;

    // R3
    sda_still_high_chk: assert property (@(posedge clk) disable iff (rst)
        !q.scl_oe |-> $stable(q.sda_oe));
    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        q.busy |=> $stable(q.hold));
    // R10
    park_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(q.busy) |-> (q.scl_oe && !q.sda_oe));
endmodule

// File: rtl/i2ctx_flags.sv
module i2ctx_flags (
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    input  logic eighth_i,
    input  logic coll_i,
    input  logic wcol_clr_i,
    input  logic finish_i,
    input  logic done_clr_i,
    input  logic sda_i,
    output logic bf_o,
    output logic wcol_o,
    output logic ack_o,
    output logic done_o
);
    typedef struct packed {
        logic bf;
        logic wcol;
        logic ack;
        logic done;
    } flag_t;

    flag_t q, d;

    always_comb begin
        d = q;
        if (accept_i)      d.bf = 1'b1;
        else if (eighth_i) d.bf = 1'b0;
        d.wcol = (q.wcol && !wcol_clr_i) || coll_i;
        d.done = (q.done && !done_clr_i) || finish_i;
        if (finish_i) d.ack = sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign bf_o   = q.bf;
    assign wcol_o = q.wcol;
    assign ack_o  = q.ack;
    assign done_o = q.done;

    // R5
    ack_capture_chk: assert property (@(posedge clk) disable iff (rst)
        finish_i |=> (q.ack == $past(sda_i)));
    // R6
    bf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        eighth_i |=> !q.bf);
    // R8
    wcol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (q.wcol && !wcol_clr_i) |=> q.wcol);
    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        finish_i |=> q.done);
endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_period_i,
    input  logic              buf_wr_i,
    input  logic [DATA_W-1:0] buf_data_i,
    input  logic              done_clr_i,
    input  logic              wcol_clr_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              buf_full_o,
    output logic              wcol_o,
    output logic              ack_stat_o,
    output logic              done_o
);
    logic busy, tick, accept, coll, eighth, finish;

    assign accept = buf_wr_i && !busy;
    assign coll   = buf_wr_i && busy;

    i2ctx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy),
        .half_i (half_period_i),
        .tick_o (tick)
    );

    i2ctx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .accept_i      (accept),
        .data_i        (buf_data_i),
        .busy_o        (busy),
        .scl_oe_o      (scl_oe_o),
        .sda_oe_o      (sda_oe_o),
        .eighth_fall_o (eighth),
        .finish_o      (finish)
    );

    i2ctx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .eighth_i   (eighth),
        .coll_i     (coll),
        .wcol_clr_i (wcol_clr_i),
        .finish_i   (finish),
        .done_clr_i (done_clr_i),
        .sda_i      (sda_i),
        .bf_o       (buf_full_o),
        .wcol_o     (wcol_o),
        .ack_o      (ack_stat_o),
        .done_o     (done_o)
    );

    // R7
    collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr_i && busy) |=> wcol_o);
endmodule

// File: tb/i2c_byte_tx_bench.sv
module i2c_byte_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [15:0] half_period = 16'd3;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       done_clr = 1'b0;
    logic       wcol_clr = 1'b0;
    logic       slave_low = 1'b0;
    logic       nack_sel = 1'b0;
    logic       sda_line;
    logic       scl_oe, sda_oe, bf, wcol, ack, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_on   = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = !(sda_oe || slave_low);

    i2c_byte_tx u_i2c_byte_tx (
        .clk           (clk),
        .rst           (rst),
        .half_period_i (half_period),
        .buf_wr_i      (wr),
        .buf_data_i    (wdata),
        .done_clr_i    (done_clr),
        .wcol_clr_i    (wcol_clr),
        .sda_i         (sda_line),
        .scl_oe_o      (scl_oe),
        .sda_oe_o      (sda_oe),
        .buf_full_o    (bf),
        .wcol_o        (wcol),
        .ack_stat_o    (ack),
        .done_o        (done)
    );

    // behavioural reference model
    bit       m_run, m_scl, m_sda, m_bf, m_wcol, m_ack, m_done;
    int       m_t, m_h;
    bit [7:0] m_byte;

    always @(posedge clk) begin
        bit run_old, line, fin;
        int hh, bb;
        if (rst) begin
            m_run = 0; m_scl = 0; m_sda = 0; m_bf = 0;
            m_wcol = 0; m_ack = 0; m_done = 0; m_t = 0; m_h = 1;
        end else begin
            run_old = m_run;
            line    = !(m_sda || slave_low);
            fin     = 0;
            if (m_run) begin
                m_t++;
                if (m_t == 16 * m_h) m_bf = 0;
                if (m_t == 18 * m_h) begin
                    m_run = 0; fin = 1; m_ack = line;
                end
            end
            m_done = (m_done && !done_clr) || fin;
            m_wcol = (m_wcol && !wcol_clr) || (wr && run_old);
            if (wr && !run_old) begin
                m_run = 1; m_t = 0; m_byte = wdata; m_bf = 1;
                m_h = (half_period == 0) ? 1 : int'(half_period);
            end
            if (m_run) begin
                hh = m_t / m_h;
                bb = hh / 2;
                m_scl = (hh % 2) == 0;
                m_sda = (bb < 8) ? !m_byte[7 - bb] : 1'b0;
            end else if (fin) begin
                m_scl = 1; m_sda = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        slave_low <= m_run && ((m_t / m_h) >= 16) && !nack_sel;
        if (cmp_on) begin
            chk("R2 scl_oe", scl_oe, m_scl);
            chk("R3/R4 sda_oe", sda_oe, m_sda);
            chk("R6 buf_full", bf, m_bf);
            chk("R7/R8 wcol", wcol, m_wcol);
            chk("R5 ack_stat", ack, m_ack);
            chk("R9 done", done, m_done);
        end
    end

    task automatic start_byte(input logic [7:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic strobe_done_clr();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1 scl released", scl_oe, 1'b0);
        chk("R1 sda released", sda_oe, 1'b0);
        chk("R1 flags clear", bf | wcol | ack | done, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R2 R3 R5: address byte, ACK, half period 3
        nack_sel = 1'b0; half_period = 16'd3;
        start_byte(8'hA5);
        chk("R2 scl low after write", scl_oe, 1'b1);
        chk("R3 msb first", sda_oe, 1'b0);
        chk("R6 full set", bf, 1'b1);
        repeat (18 * 3) @(negedge clk);
        chk("R9 done set", done, 1'b1);
        chk("R5 ack low", ack, 1'b0);
        chk("R10 parked scl low", scl_oe, 1'b1);
        repeat (5) @(negedge clk);
        chk("R10 no activity", scl_oe, 1'b1);
        strobe_done_clr();
        chk("R9 done cleared", done, 1'b0);

        // R10 R5: next byte from parked bus, NACK, half period 1
        nack_sel = 1'b1; half_period = 16'd1;
        start_byte(8'h3C);
        repeat (20) @(negedge clk);
        chk("R5 nack high", ack, 1'b1);

        // R2: half period 0 behaves as 1
        nack_sel = 1'b0; half_period = 16'd0;
        start_byte(8'h81);
        repeat (20) @(negedge clk);
        chk("R5 ack after zero period", ack, 1'b0);

        // R7 R8: collision mid-byte, then clear with simultaneous new collision
        half_period = 16'd4;
        start_byte(8'h5A);
        repeat (10) @(negedge clk);
        wr = 1'b1; wdata = 8'hFF;
        @(negedge clk); wr = 1'b0;
        chk("R7 collision flagged", wcol, 1'b1);
        repeat (3) @(negedge clk);
        wr = 1'b1; wcol_clr = 1'b1;
        @(negedge clk); wr = 1'b0; wcol_clr = 1'b0;
        chk("R8 set wins over clear", wcol, 1'b1);
        @(negedge clk); wcol_clr = 1'b1;
        @(negedge clk); wcol_clr = 1'b0;
        chk("R8 cleared by strobe", wcol, 1'b0);
        repeat (80) @(negedge clk);

        // R7 R9: write on the finishing edge collides; done clear loses to set
        half_period = 16'd2;
        strobe_done_clr();
        start_byte(8'hC3);
        repeat (18 * 2 - 1) @(negedge clk);
        wr = 1'b1; wdata = 8'h00; done_clr = 1'b1;
        @(negedge clk); wr = 1'b0; done_clr = 1'b0;
        chk("R7 collide at finish", wcol, 1'b1);
        chk("R9 set wins over clear", done, 1'b1);
        chk("R10 parked after collision", scl_oe, 1'b1);
        repeat (10) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule